// File: doc/BRIEF.md
# Grouped Level Interrupt Combiner

This block gathers level-sensitive interrupt sources into groups of eight and drives one request line per group towards a parent interrupt controller. Each source has an enable bit. A group line is raised while at least one of its sources is both high and enabled. Software sets enable bits through one register and clears them through another. Each write changes only the bits written as 1, so no read-modify-write is needed and concurrent handlers cannot lose updates.

Four groups share one 32-bit register bank, one byte lane per group. Banks follow each other at a 16-byte stride, so the group count sets the number of banks. A status register shows which sources are currently active and enabled. The parent controller then needs only the group line, and software reads the status word to find the source.

Top module: `icomb_top`

## Requirements
- R1: After a synchronous reset, all enable bits are 0, every group line is low and the read data is 0.
- R2: A write to bank offset 0x0 sets each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R3: A write to bank offset 0x4 clears each enable bit whose write-data bit is 1. Bits written as 0 keep their value.
- R4: Reads at offset 0x0 and at offset 0x4 both return the bank's current enable word. Read data is registered: it appears one clock after the address and reflects register state from before that clock edge.
- R5: Offset 0xC returns the status word. This is the source levels ANDed with the enables, captured on the previous clock edge. Writes to 0xC change nothing.
- R6: Group g sits in bank g/4, byte lane g mod 4 (bits 8*(g mod 4)+7 down to 8*(g mod 4)). Source input index 8*g+b maps to bit b of that lane.
- R7: Bank k occupies byte addresses 0x10*k to 0x10*k+0xF. The bank index is address bits above bit 3.
- R8: Group line g is high one clock after an edge at which any source of group g was high with its enable bit set. It is low one clock after an edge at which none was.
- R9: Offsets 0x8 and 0xD to 0xF, all other offsets not listed above, and banks beyond the last group read as 0. Writes to any of these change no state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_addr | input | ADDR_W | Byte address for read and write |
| reg_wdata | input | 32 | Write data |
| reg_wr | input | 1 | Write strobe, one write per cycle |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |
| src_level | input | 8*NUM_GROUPS | Level-sensitive interrupt sources |
| grp_irq | output | NUM_GROUPS | Registered request line per group |

## Verification
A bad enable bit appears in two places. The group line for a high source becomes wrong one cycle after the edge, and a read of offset 0x0 or 0x4 shows the wrong bit one cycle after the address is presented. Wrong lane or bank decode puts a write or a source into a neighbouring group. Its line or status byte then differs from the expected value on the next read. Random source levels and mixed set, clear and unmapped writes are checked every cycle against a bench model, so a corrupted state shows up within a few cycles.

// File: rtl/icomb_pkg.sv
package icomb_pkg;
  localparam int GRP_W    = 8;
  localparam int LANES    = 4;
  localparam int WORD_W   = GRP_W * LANES;
  localparam int OFF_W    = 4;

  localparam logic [OFF_W-1:0] OFF_EN_SET = 4'h0;
  localparam logic [OFF_W-1:0] OFF_EN_CLR = 4'h4;
  localparam logic [OFF_W-1:0] OFF_STAT   = 4'hC;

  typedef enum logic [1:0] {
    SEL_NONE = 2'd0,
    SEL_EN   = 2'd1,
    SEL_STAT = 2'd2
  } rd_sel_e;
endpackage

// File: rtl/icomb_decode.sv
module icomb_decode
  import icomb_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int ADDR_W    = 8,
  parameter int BANK_W    = 1
) (
  input  logic [ADDR_W-1:0]    addr,
  input  logic                 wr,
  output logic [NUM_BANKS-1:0] set_stb,
  output logic [NUM_BANKS-1:0] clr_stb,
  output rd_sel_e              rd_sel,
  output logic [BANK_W-1:0]    rd_bank
);
  localparam int UB_W = ADDR_W - OFF_W;

  logic [UB_W-1:0]  upper;
  logic [OFF_W-1:0] off;
  logic             bank_hit;

  assign upper    = addr[ADDR_W-1:OFF_W];
  assign off      = addr[OFF_W-1:0];
  assign bank_hit = 32'(upper) < NUM_BANKS;
  assign rd_bank  = upper[BANK_W-1:0];

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_stb
    assign set_stb[b] = wr && (32'(upper) == b) && (off == OFF_EN_SET);
    assign clr_stb[b] = wr && (32'(upper) == b) && (off == OFF_EN_CLR);
  end

  always_comb begin
    rd_sel = SEL_NONE;
    if (bank_hit) begin
      if (off == OFF_EN_SET || off == OFF_EN_CLR) rd_sel = SEL_EN;
      else if (off == OFF_STAT)                   rd_sel = SEL_STAT;
    end
  end
endmodule

// File: rtl/icomb_group.sv
module icomb_group
  import icomb_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             set_stb,
  input  logic             clr_stb,
  input  logic [GRP_W-1:0] wbyte,
  input  logic [GRP_W-1:0] src,
  output logic [GRP_W-1:0] en_o,
  output logic [GRP_W-1:0] stat_o,
  output logic             irq_o
);
  logic [GRP_W-1:0] en_q, stat_q;
  logic             irq_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      if (set_stb)      en_q <= en_q | wbyte;
      else if (clr_stb) en_q <= en_q & ~wbyte;
      stat_q <= src & en_q;
      irq_q  <= |(src & en_q);
    end
  end

  assign en_o   = en_q;
  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  // R2
  set_lands_chk: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((en_q & $past(wbyte)) == $past(wbyte)));
  // R2
  set_keeps_chk: assert property (@(posedge clk) disable iff (rst)
    set_stb |=> ((en_q & ~$past(wbyte)) == ($past(en_q) & ~$past(wbyte))));
  // R3
  clr_lands_chk: assert property (@(posedge clk) disable iff (rst)
    clr_stb |=> ((en_q & $past(wbyte)) == '0));
  // R9
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!set_stb && !clr_stb) |=> $stable(en_q));
  // R5
  stat_masked_chk: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((stat_q & ~$past(en_q)) == '0));
endmodule

// File: rtl/icomb_rdmux.sv
module icomb_rdmux
  import icomb_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int NUM_BANKS  = 2,
  parameter int BANK_W     = 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NUM_GROUPS*GRP_W-1:0] en_all,
  input  logic [NUM_GROUPS*GRP_W-1:0] stat_all,
  input  rd_sel_e                     rd_sel,
  input  logic [BANK_W-1:0]           rd_bank,
  output logic [WORD_W-1:0]           rdata
);
  logic [WORD_W-1:0] en_word   [NUM_BANKS];
  logic [WORD_W-1:0] stat_word [NUM_BANKS];
  logic [WORD_W-1:0] rdata_q;

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      if (b * LANES + l < NUM_GROUPS) begin : g_used
        assign en_word[b][l*GRP_W +: GRP_W]   = en_all[(b*LANES+l)*GRP_W +: GRP_W];
        assign stat_word[b][l*GRP_W +: GRP_W] = stat_all[(b*LANES+l)*GRP_W +: GRP_W];
      end else begin : g_empty
        assign en_word[b][l*GRP_W +: GRP_W]   = '0;
        assign stat_word[b][l*GRP_W +: GRP_W] = '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else begin
      case (rd_sel)
        SEL_EN:   rdata_q <= en_word[rd_bank];
        SEL_STAT: rdata_q <= stat_word[rd_bank];
        default:  rdata_q <= '0;
      endcase
    end
  end

  assign rdata = rdata_q;

  // R9
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == SEL_NONE) |=> (rdata == '0));
endmodule

// File: rtl/icomb_top.sv
module icomb_top
  import icomb_pkg::*;
#(
  parameter int NUM_GROUPS = 8,
  parameter int ADDR_W     = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [31:0]                 reg_wdata,
  input  logic                        reg_wr,
  output logic [31:0]                 reg_rdata,
  input  logic [NUM_GROUPS*8-1:0]     src_level,
  output logic [NUM_GROUPS-1:0]       grp_irq
);
  localparam int NUM_BANKS = (NUM_GROUPS + LANES - 1) / LANES;
  localparam int BANK_W    = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1;
  localparam int NSRC      = NUM_GROUPS * GRP_W;

  logic [NUM_BANKS-1:0] set_stb, clr_stb;
  rd_sel_e              rd_sel;
  logic [BANK_W-1:0]    rd_bank;
  logic [NSRC-1:0]      en_all, stat_all;

  icomb_decode #(
    .NUM_BANKS (NUM_BANKS),
    .ADDR_W    (ADDR_W),
    .BANK_W    (BANK_W)
  ) u_dec (
    .addr    (reg_addr),
    .wr      (reg_wr),
    .set_stb (set_stb),
    .clr_stb (clr_stb),
    .rd_sel  (rd_sel),
    .rd_bank (rd_bank)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    localparam int BK = g / LANES;
    localparam int LN = g % LANES;

    icomb_group u_grp (
      .clk     (clk),
      .rst     (rst),
      .set_stb (set_stb[BK]),
      .clr_stb (clr_stb[BK]),
      .wbyte   (reg_wdata[LN*GRP_W +: GRP_W]),
      .src     (src_level[g*GRP_W +: GRP_W]),
      .en_o    (en_all[g*GRP_W +: GRP_W]),
      .stat_o  (stat_all[g*GRP_W +: GRP_W]),
      .irq_o   (grp_irq[g])
    );

    // R8
    quiet_src_chk: assert property (@(posedge clk) disable iff (rst)
      (src_level[g*GRP_W +: GRP_W] == '0) |=> !grp_irq[g]);
  end

  icomb_rdmux #(
    .NUM_GROUPS (NUM_GROUPS),
    .NUM_BANKS  (NUM_BANKS),
    .BANK_W     (BANK_W)
  ) u_rd (
    .clk      (clk),
    .rst      (rst),
    .en_all   (en_all),
    .stat_all (stat_all),
    .rd_sel   (rd_sel),
    .rd_bank  (rd_bank),
    .rdata    (reg_rdata)
  );

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> (grp_irq == '0 && reg_rdata == '0));
endmodule

// File: tb/tb_icomb_top.sv
`timescale 1ns/1ps
module tb_icomb_top;
  localparam int NG = 8;
  localparam int NB = (NG + 3) / 4;
  localparam int NS = NG * 8;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [7:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic          reg_wr = 1'b0;
  logic [31:0]   reg_rdata;
  logic [NS-1:0] src_level = '0;
  logic [NG-1:0] grp_irq;

  icomb_top #(.NUM_GROUPS(NG), .ADDR_W(8)) dut (
    .clk(clk), .rst(rst), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .src_level(src_level), .grp_irq(grp_irq)
  );

  always #4 clk = ~clk;

  int total = 0;
  int fails = 0;
  logic [NS-1:0] en_m = '0;
  logic [NS-1:0] stat_m = '0;
  logic [NS-1:0] src_cur = '0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_rd(input logic [7:0] a);
    int b = int'(a >> 4);
    int off = int'(a & 8'h0F);
    logic [31:0] r = '0;
    if (b < NB)
      for (int l = 0; l < 4; l++) begin
        int g = b * 4 + l;
        if (g < NG) begin
          if (off == 0 || off == 4) r[l*8 +: 8] = en_m[g*8 +: 8];
          else if (off == 12)       r[l*8 +: 8] = stat_m[g*8 +: 8];
        end
      end
    return r;
  endfunction

  function automatic string rd_tag(input logic [7:0] a);
    int b = int'(a >> 4);
    int off = int'(a & 8'h0F);
    if (b >= NB) return "R9 bank out of range";
    if (off == 0 || off == 4) return "R4 enable readback";
    if (off == 12) return "R5 status";
    return "R9 unmapped offset";
  endfunction

  task automatic cyc(input logic [7:0] a, input logic [31:0] d, input logic w);
    logic [31:0]   exp_rd;
    logic [NG-1:0] exp_irq;
    int b, off;
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = w; src_level = src_cur;
    @(posedge clk);
    exp_rd = model_rd(a);
    for (int g = 0; g < NG; g++) exp_irq[g] = |(src_cur[g*8 +: 8] & en_m[g*8 +: 8]);
    stat_m = src_cur & en_m;
    b = int'(a >> 4);
    off = int'(a & 8'h0F);
    if (w && b < NB)
      for (int l = 0; l < 4; l++) begin
        int g = b * 4 + l;
        if (g < NG) begin
          if (off == 0)      en_m[g*8 +: 8] = en_m[g*8 +: 8] | d[l*8 +: 8];
          else if (off == 4) en_m[g*8 +: 8] = en_m[g*8 +: 8] & ~d[l*8 +: 8];
        end
      end
    #2;
    chk(rd_tag(a), 64'(reg_rdata), 64'(exp_rd));
    chk("R8 group lines", 64'(grp_irq), 64'(exp_irq));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++; total++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    #1;
    chk("R1 reset rdata", 64'(reg_rdata), 64'd0);
    chk("R1 reset lines", 64'(grp_irq), 64'd0);
    cyc(8'h00, 32'h0, 1'b0);
    chk("R1 reset enables", 64'(reg_rdata), 64'd0);

    cyc(8'h00, 32'h0000_00A5, 1'b1);
    cyc(8'h00, 32'h0, 1'b1);
    cyc(8'h00, 32'h0, 1'b0);
    chk("R2 set and zero bits", 64'(reg_rdata), 64'h0000_00A5);
    cyc(8'h04, 32'h0000_0005, 1'b1);
    cyc(8'h04, 32'h0, 1'b0);
    chk("R3 clear and zero bits", 64'(reg_rdata), 64'h0000_00A0);

    src_cur[5] = 1'b1; src_cur[13] = 1'b1;
    cyc(8'h0C, 32'h0, 1'b0);
    chk("R8 group0 line", 64'(grp_irq[0]), 64'd1);
    chk("R6 group1 disabled", 64'(grp_irq[1]), 64'd0);
    cyc(8'h0C, 32'h0, 1'b0);
    chk("R5 R6 status lane0", 64'(reg_rdata), 64'h0000_0020);

    cyc(8'h10, 32'h0000_FF00, 1'b1);
    src_cur[43] = 1'b1;
    cyc(8'h14, 32'h0, 1'b0);
    chk("R7 bank1 enable", 64'(reg_rdata), 64'h0000_FF00);
    chk("R7 group5 line", 64'(grp_irq[5]), 64'd1);
    cyc(8'h1C, 32'h0, 1'b0);
    chk("R7 bank1 status", 64'(reg_rdata), 64'h0000_0800);

    cyc(8'h08, 32'hFFFF_FFFF, 1'b1);
    cyc(8'h0C, 32'hFFFF_FFFF, 1'b1);
    cyc(8'h0D, 32'hFFFF_FFFF, 1'b1);
    cyc(8'h20, 32'hFFFF_FFFF, 1'b1);
    cyc(8'h00, 32'h0, 1'b0);
    chk("R9 ignored writes", 64'(reg_rdata), 64'h0000_00A0);
    cyc(8'h08, 32'h0, 1'b0);
    chk("R9 offset 0x8 reads zero", 64'(reg_rdata), 64'd0);
    cyc(8'h20, 32'h0, 1'b0);
    chk("R9 missing bank reads zero", 64'(reg_rdata), 64'd0);

    for (int i = 0; i < 3000; i++) begin
      logic [7:0] a;
      int pick = int'($urandom_range(0, 11));
      case (pick)
        0: a = 8'h00;  1: a = 8'h04;  2: a = 8'h0C;  3: a = 8'h10;
        4: a = 8'h14;  5: a = 8'h1C;  6: a = 8'h08;  7: a = 8'h1E;
        8: a = 8'h30;  9: a = 8'h01;  10: a = 8'h18;
        default: a = 8'($urandom);
      endcase
      if (i % 16 == 0) src_cur = {$urandom, $urandom};
      cyc(a, $urandom, 1'($urandom_range(0, 2) == 0));
    end

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule